// File: doc/BRIEF.md
# Virtual CPU Interrupt Interface

This block is the guest-facing side of a virtualized interrupt controller for one processor. The hypervisor takes each physical interrupt itself, then injects it into the running guest by writing a list register: a small set of entries, each holding a virtual interrupt ID, a priority and a lifecycle state. The block compares the most urgent pending entry against the guest's priority mask and its running priority, and it raises a virtual IRQ line to the core when that entry may preempt.

The guest's handler works only with its own virtual registers. It acknowledges by reading the acknowledge register, which returns an ID and marks that entry active. It retires the interrupt by writing the ID to the end-of-interrupt register. It changes masking by writing the priority mask. None of these accesses traps. The hypervisor uses a separate port to write and read the list registers, and an all-empty flag tells it when the entries can be refilled.

Each list register is a four-state machine: LR_INVALID, LR_PENDING, LR_ACTIVE and LR_PEND_ACT. A hypervisor write (load) moves an entry to any state. An acknowledge (take) moves LR_PENDING to LR_ACTIVE. An end-of-interrupt (retire) moves LR_ACTIVE to LR_INVALID and LR_PEND_ACT to LR_PENDING. LR_INVALID has no guest transition.

Top module: `vcpu_irq_if`

## Requirements
- R1: After reset, every list register reads as all zeros (invalid), hv_all_empty is 1, virq is 0, and the priority mask is 0, which masks every priority.
- R2: A hypervisor write loads entry hv_wr_idx from hv_wr_data: bits [16:7] are the ID, bits [6:2] are the priority (a lower value is more urgent) and bits [1:0] are the state, with 00 invalid, 01 pending, 10 active and 11 pending-and-active. hv_rd_data returns the entry selected by hv_rd_idx in the same layout, in the same cycle.
- R3: hv_all_empty is 1 exactly when every entry is invalid.
- R4: virq is 1 exactly when there is a pending entry whose priority is strictly below the mask and strictly below the running priority. The running priority is the lowest priority value among active and pending-and-active entries, and it imposes no limit when there are none.
- R5: Pending-and-active entries are never candidates for virq or acknowledge, but they do set the running priority.
- R6: When an acknowledge is requested, gu_ack_vld is 1 in the next cycle. If virq was 1, gu_ack_id is the ID of the most urgent pending entry, ties go to the lowest index, and that entry becomes active.
- R7: An acknowledge while virq is 0 returns ID 1023 and changes no entry.
- R8: An end-of-interrupt with an ID retires the lowest-index active or pending-and-active entry with that ID: active becomes invalid, and pending-and-active becomes pending. If no entry matches, nothing changes.
- R9: A mask write takes effect from the next cycle.
- R10: When a hypervisor write and a guest acknowledge or end-of-interrupt target the same entry in the same cycle, the hypervisor's content is the one kept.
- R11: An acknowledge and an end-of-interrupt in the same cycle both take effect, and the acknowledge decision uses the running priority from before that end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hv_wr_en | input | 1 | Hypervisor list-register write strobe |
| hv_wr_idx | input | 2 | Entry to write |
| hv_wr_data | input | 17 | Entry content {ID, priority, state} |
| hv_rd_idx | input | 2 | Entry to read |
| hv_rd_data | output | 17 | Content of the selected entry |
| hv_all_empty | output | 1 | Every entry is invalid |
| gu_ack_req | input | 1 | Guest read of the acknowledge register |
| gu_ack_vld | output | 1 | Acknowledge result valid |
| gu_ack_id | output | 10 | Acknowledged ID, or 1023 |
| gu_eoi_req | input | 1 | Guest end-of-interrupt write |
| gu_eoi_id | input | 10 | ID being retired |
| gu_pmr_wr | input | 1 | Guest priority-mask write |
| gu_pmr_data | input | 5 | New mask value |
| virq | output | 1 | Virtual IRQ to the core |

## Verification
The collision of interest is a guest acknowledge and a guest end-of-interrupt in the same cycle. The acknowledge must choose its entry against the running priority that was in force before the retire, while the retire frees a different entry. Directed steps set up one active entry and a more urgent pending-and-active entry, retire it back to pending, and then issue an acknowledge together with an end-of-interrupt. The bench compares the acknowledged ID, every entry's read-back and virq with a behavioural model on every clock. Random traffic then mixes these two operations with hypervisor writes to the same entries.

// File: rtl/vcif_pkg.sv
package vcif_pkg;

    // Lifecycle of one list register; encoding is visible on the hypervisor port.
    typedef enum logic [1:0] {
        LR_INVALID  = 2'b00,
        LR_PENDING  = 2'b01,
        LR_ACTIVE   = 2'b10,
        LR_PEND_ACT = 2'b11
    } lr_state_e;

endpackage

// File: rtl/vcif_lr_entry.sv
module vcif_lr_entry
    import vcif_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ID_W-1:0]   load_id,
    input  logic [PRIO_W-1:0] load_prio,
    input  lr_state_e         load_state,
    input  logic              take,
    input  logic              retire,
    output logic [ID_W-1:0]   id,
    output logic [PRIO_W-1:0] prio,
    output lr_state_e         state,
    output logic              is_pending,
    output logic              is_active
);

    lr_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [PRIO_W-1:0] prio_q;

    // State register and payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LR_INVALID;
            id_q    <= '0;
            prio_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                id_q   <= load_id;
                prio_q <= load_prio;
            end
        end
    end

    // Transitions: a hypervisor load overrides any guest event
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = load_state;
        end else begin
            unique case (state_q)
                LR_INVALID:  state_d = LR_INVALID;
                LR_PENDING:  if (take)   state_d = LR_ACTIVE;
                LR_ACTIVE:   if (retire) state_d = LR_INVALID;
                LR_PEND_ACT: if (retire) state_d = LR_PENDING;
                default:     state_d = LR_INVALID;
            endcase
        end
    end

    // Outputs
    always_comb begin
        id         = id_q;
        prio       = prio_q;
        state      = state_q;
        is_pending = (state_q == LR_PENDING);
        is_active  = (state_q == LR_ACTIVE) || (state_q == LR_PEND_ACT);
    end

endmodule

// File: rtl/vcif_prio_sel.sv
module vcif_prio_sel #(
    parameter int N      = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 5,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             pend_vec,
    input  logic [N-1:0]             act_vec,
    input  logic [N-1:0][PRIO_W-1:0] prio_vec,
    output logic                     pend_found,
    output logic [IDX_W-1:0]         pend_idx,
    output logic [PRIO_W-1:0]        pend_prio,
    output logic [PRIO_W:0]          run_prio
);

    localparam logic [PRIO_W:0] RUN_IDLE = {1'b1, {PRIO_W{1'b0}}};

    // Strict compare while scanning upward keeps the lowest index on ties.
    always_comb begin
        pend_found = 1'b0;
        pend_idx   = '0;
        pend_prio  = '1;
        run_prio   = RUN_IDLE;
        for (int i = 0; i < N; i++) begin
            if (pend_vec[i] && (!pend_found || prio_vec[i] < pend_prio)) begin
                pend_found = 1'b1;
                pend_idx   = IDX_W'(i);
                pend_prio  = prio_vec[i];
            end
            if (act_vec[i] && ({1'b0, prio_vec[i]} < run_prio)) begin
                run_prio = {1'b0, prio_vec[i]};
            end
        end
    end

endmodule

// File: rtl/vcif_eoi_match.sv
module vcif_eoi_match #(
    parameter int N    = 4,
    parameter int ID_W = 10
) (
    input  logic                   eoi_req,
    input  logic [ID_W-1:0]        eoi_id,
    input  logic [N-1:0]           act_vec,
    input  logic [N-1:0][ID_W-1:0] id_vec,
    output logic [N-1:0]           retire_vec
);

    logic hit;

    // Only the lowest-index matching active entry is retired.
    always_comb begin
        hit        = 1'b0;
        retire_vec = '0;
        for (int i = 0; i < N; i++) begin
            if (eoi_req && !hit && act_vec[i] && id_vec[i] == eoi_id) begin
                retire_vec[i] = 1'b1;
                hit           = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vcpu_irq_if.sv
module vcpu_irq_if
    import vcif_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 5,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int LR_W  = ID_W + PRIO_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_wr_en,
    input  logic [IDX_W-1:0]  hv_wr_idx,
    input  logic [LR_W-1:0]   hv_wr_data,
    input  logic [IDX_W-1:0]  hv_rd_idx,
    output logic [LR_W-1:0]   hv_rd_data,
    output logic              hv_all_empty,
    input  logic              gu_ack_req,
    output logic              gu_ack_vld,
    output logic [ID_W-1:0]   gu_ack_id,
    input  logic              gu_eoi_req,
    input  logic [ID_W-1:0]   gu_eoi_id,
    input  logic              gu_pmr_wr,
    input  logic [PRIO_W-1:0] gu_pmr_data,
    output logic              virq
);

    localparam logic [ID_W-1:0] SPURIOUS_ID = {ID_W{1'b1}};

    logic [NUM_LR-1:0]             pend_vec;
    logic [NUM_LR-1:0]             act_vec;
    logic [NUM_LR-1:0]             valid_vec;
    logic [NUM_LR-1:0]             retire_vec;
    logic [NUM_LR-1:0][ID_W-1:0]   id_vec;
    logic [NUM_LR-1:0][PRIO_W-1:0] prio_vec;
    lr_state_e                     state_vec [NUM_LR];

    logic              pend_found;
    logic [IDX_W-1:0]  pend_idx;
    logic [PRIO_W-1:0] pend_prio;
    logic [PRIO_W:0]   run_prio;
    logic [PRIO_W-1:0] pmr_q;
    logic              eligible;
    logic              ack_take;
    logic              ack_vld_q;
    logic [ID_W-1:0]   ack_id_q;

    // List registers
    for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
        logic wr_hit;
        assign wr_hit = hv_wr_en && (hv_wr_idx == IDX_W'(g));

        vcif_lr_entry #(
            .ID_W   (ID_W),
            .PRIO_W (PRIO_W)
        ) u_lr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (wr_hit),
            .load_id    (hv_wr_data[LR_W-1 -: ID_W]),
            .load_prio  (hv_wr_data[2 +: PRIO_W]),
            .load_state (lr_state_e'(hv_wr_data[1:0])),
            .take       (ack_take && (pend_idx == IDX_W'(g))),
            .retire     (retire_vec[g]),
            .id         (id_vec[g]),
            .prio       (prio_vec[g]),
            .state      (state_vec[g]),
            .is_pending (pend_vec[g]),
            .is_active  (act_vec[g])
        );

        assign valid_vec[g] = (state_vec[g] != LR_INVALID);
    end

    vcif_prio_sel #(
        .N      (NUM_LR),
        .ID_W   (ID_W),
        .PRIO_W (PRIO_W)
    ) u_sel (
        .pend_vec   (pend_vec),
        .act_vec    (act_vec),
        .prio_vec   (prio_vec),
        .pend_found (pend_found),
        .pend_idx   (pend_idx),
        .pend_prio  (pend_prio),
        .run_prio   (run_prio)
    );

    vcif_eoi_match #(
        .N    (NUM_LR),
        .ID_W (ID_W)
    ) u_eoi (
        .eoi_req    (gu_eoi_req),
        .eoi_id     (gu_eoi_id),
        .act_vec    (act_vec),
        .id_vec     (id_vec),
        .retire_vec (retire_vec)
    );

    // Preemption decision
    always_comb begin
        eligible = pend_found
                && (pend_prio < pmr_q)
                && ({1'b0, pend_prio} < run_prio);
        ack_take = gu_ack_req && eligible;
    end

    // Guest mask and acknowledge response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmr_q     <= '0;
            ack_vld_q <= 1'b0;
            ack_id_q  <= '0;
        end else begin
            if (gu_pmr_wr) pmr_q <= gu_pmr_data;
            ack_vld_q <= gu_ack_req;
            if (gu_ack_req) ack_id_q <= eligible ? id_vec[pend_idx] : SPURIOUS_ID;
        end
    end

    always_comb begin
        virq         = eligible;
        gu_ack_vld   = ack_vld_q;
        gu_ack_id    = ack_id_q;
        hv_all_empty = ~|valid_vec;
        hv_rd_data   = {id_vec[hv_rd_idx], prio_vec[hv_rd_idx], state_vec[hv_rd_idx]};
    end

endmodule

// File: rtl/vcpu_irq_chk.sv
module vcpu_irq_chk #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 5,
    parameter int LR_W   = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_wr_en,
    input logic [LR_W-1:0]   hv_wr_data,
    input logic              hv_all_empty,
    input logic              gu_ack_req,
    input logic              gu_ack_vld,
    input logic [ID_W-1:0]   gu_ack_id,
    input logic              gu_pmr_wr,
    input logic [PRIO_W-1:0] gu_pmr_data,
    input logic              virq
);

    // R3
    virq_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        virq |-> !hv_all_empty);

    // R7
    spurious_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gu_ack_req && !virq) |=> (gu_ack_vld && gu_ack_id == {ID_W{1'b1}}));

    // R6
    ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gu_ack_req |=> gu_ack_vld);

    // R6
    ack_no_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gu_ack_req |=> !gu_ack_vld);

    // R9
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gu_pmr_wr && gu_pmr_data == '0) |=> !virq);

    // R2
    fill_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_wr_en && hv_wr_data[1:0] != 2'b00) |=> !hv_all_empty);

endmodule

bind vcpu_irq_if vcpu_irq_chk #(
    .ID_W   (ID_W),
    .PRIO_W (PRIO_W),
    .LR_W   (LR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hv_wr_en     (hv_wr_en),
    .hv_wr_data   (hv_wr_data),
    .hv_all_empty (hv_all_empty),
    .gu_ack_req   (gu_ack_req),
    .gu_ack_vld   (gu_ack_vld),
    .gu_ack_id    (gu_ack_id),
    .gu_pmr_wr    (gu_pmr_wr),
    .gu_pmr_data  (gu_pmr_data),
    .virq         (virq)
);

// File: tb/sim_vcpu_irq_if.sv
`timescale 1ns/100ps
module sim_vcpu_irq_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_wr_en = 1'b0;
    logic [1:0]  hv_wr_idx = '0;
    logic [16:0] hv_wr_data = '0;
    logic [1:0]  hv_rd_idx = '0;
    logic [16:0] hv_rd_data;
    logic        hv_all_empty;
    logic        gu_ack_req = 1'b0;
    logic        gu_ack_vld;
    logic [9:0]  gu_ack_id;
    logic        gu_eoi_req = 1'b0;
    logic [9:0]  gu_eoi_id = '0;
    logic        gu_pmr_wr = 1'b0;
    logic [4:0]  gu_pmr_data = '0;
    logic        virq;

    always #2.5 clk = ~clk;

    vcpu_irq_if u0 (
        .clk(clk), .rst_n(rst_n),
        .hv_wr_en(hv_wr_en), .hv_wr_idx(hv_wr_idx), .hv_wr_data(hv_wr_data),
        .hv_rd_idx(hv_rd_idx), .hv_rd_data(hv_rd_data), .hv_all_empty(hv_all_empty),
        .gu_ack_req(gu_ack_req), .gu_ack_vld(gu_ack_vld), .gu_ack_id(gu_ack_id),
        .gu_eoi_req(gu_eoi_req), .gu_eoi_id(gu_eoi_id),
        .gu_pmr_wr(gu_pmr_wr), .gu_pmr_data(gu_pmr_data), .virq(virq)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // Reference model
    int m_st [4];
    int m_id [4];
    int m_pr [4];
    int m_pmr = 0;
    bit m_ack_vld = 0;
    int m_ack_id = 0;

    function automatic bit model_virq();
        int bp = 99;
        int run = 32;
        for (int i = 0; i < 4; i++) begin
            if (m_st[i] == 1 && m_pr[i] < bp) bp = m_pr[i];
            if (m_st[i] >= 2 && m_pr[i] < run) run = m_pr[i];
        end
        return (bp < 99) && (bp < m_pmr) && (bp < run);
    endfunction

    task automatic cmp(input string tag, input int got, input int exp, input string what);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL [%s] %s got %0d expected %0d at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    task automatic step(input bit wr, input int widx, input int wid, input int wpr, input int wst,
                        input bit ack, input bit eoi, input int eid,
                        input bit pw, input int pd, input int ridx, input string tag);
        int best, bp, run, eo;
        bit elig;
        hv_wr_en    = wr;
        hv_wr_idx   = widx[1:0];
        hv_wr_data  = {wid[9:0], wpr[4:0], wst[1:0]};
        gu_ack_req  = ack;
        gu_eoi_req  = eoi;
        gu_eoi_id   = eid[9:0];
        gu_pmr_wr   = pw;
        gu_pmr_data = pd[4:0];
        hv_rd_idx   = ridx[1:0];
        @(posedge clk);
        best = -1; bp = 99; run = 32; eo = -1;
        for (int i = 0; i < 4; i++) begin
            if (m_st[i] == 1 && m_pr[i] < bp) begin best = i; bp = m_pr[i]; end
            if (m_st[i] >= 2 && m_pr[i] < run) run = m_pr[i];
            if (eoi && eo < 0 && m_st[i] >= 2 && m_id[i] == eid) eo = i;
        end
        elig = (best >= 0) && (bp < m_pmr) && (bp < run);
        m_ack_vld = ack;
        if (ack) m_ack_id = elig ? m_id[best] : 1023;
        for (int i = 0; i < 4; i++) begin
            if (wr && widx == i) begin
                m_st[i] = wst; m_id[i] = wid; m_pr[i] = wpr;
            end else if (ack && elig && i == best) begin
                m_st[i] = 2;
            end else if (i == eo) begin
                m_st[i] = (m_st[i] == 2) ? 0 : 1;
            end
        end
        if (pw) m_pmr = pd;
        @(negedge clk);
        cmp(tag, int'(virq), int'(model_virq()), "virq");
        cmp(tag, int'(hv_all_empty),
            int'(m_st[0] == 0 && m_st[1] == 0 && m_st[2] == 0 && m_st[3] == 0), "all_empty");
        cmp(tag, int'(hv_rd_data), (m_id[ridx] << 7) | (m_pr[ridx] << 2) | m_st[ridx], "rd_data");
        cmp(tag, int'(gu_ack_vld), int'(m_ack_vld), "ack_vld");
        if (m_ack_vld) cmp(tag, int'(gu_ack_id), m_ack_id, "ack_id");
    endtask

    task automatic idle(input int ridx, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ridx, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL [watchdog] run hung: got cycle %0d expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_id[i] = 0; m_pr[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every entry, flag, line and mask
        for (int i = 0; i < 4; i++) idle(i, "R1");
        // R1: mask 0 blocks even the most urgent priority
        step(1, 3, 1, 0, 1, 0, 0, 0, 0, 0, 3, "R1");
        step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 3, "R3");
        // R9: mask opens one cycle after the write
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 31, 0, "R9");
        // R2 / R4: single pending entry raises virq
        step(1, 2, 7, 10, 1, 0, 0, 0, 0, 0, 2, "R2");
        step(1, 1, 9, 10, 1, 0, 0, 0, 0, 0, 1, "R4");
        // R6: equal priority goes to the lower index (ID 9)
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R6");
        // R7: running priority 10 blocks the other priority-10 entry
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 2, "R7");
        // R5: pending-and-active entry sets running priority 3 but is not a candidate
        step(1, 0, 4, 3, 3, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
        // R8: retiring ID 4 turns pending-and-active into pending
        step(0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0, "R8");
        // R11: acknowledge ID 4 while ID 9 is retired in the same cycle
        step(0, 0, 0, 0, 0, 1, 1, 9, 0, 0, 1, "R11");
        idle(0, "R11");
        // R8: unmatched ID changes nothing
        step(0, 0, 0, 0, 0, 0, 1, 55, 0, 0, 0, "R8");
        // R10: hypervisor write beats the retire of the same entry
        step(1, 0, 12, 2, 1, 0, 1, 4, 0, 0, 0, "R10");
        // R10: hypervisor write beats the acknowledge of the same entry
        step(1, 0, 13, 2, 1, 1, 0, 0, 0, 0, 0, "R10");
        // R9: mask equal to the priority blocks it; one above admits it
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 0, "R9");
        // Mixed random traffic with collisions
        for (int k = 0; k < 4000; k++) begin
            bit wr, ack, eoi, pw;
            int pd;
            wr  = ($urandom_range(0, 3) == 0);
            ack = ($urandom_range(0, 2) == 0);
            eoi = ($urandom_range(0, 2) == 0);
            pw  = ($urandom_range(0, 11) == 0);
            pd  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : 31 - $urandom_range(0, 4);
            step(wr, $urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 7) * 4,
                 $urandom_range(0, 3), ack, eoi, $urandom_range(0, 5), pw, pd,
                 $urandom_range(0, 3), "R2 R3 R4 R6 R7 R8 R10 R11");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule